// File: doc/BRIEF.md
# USB IN Endpoint Commit Controller

This block is the transmit half of a single USB function IN endpoint. A local processor fills a packet store byte by byte, then raises a one-cycle commit strobe. The commit freezes the byte count into a valid-size register and arms the endpoint. Until that moment the transmitter treats the endpoint as empty. This means a packet that is still being written can never leave the device. A commit with no bytes written arms a deliberate zero-length packet.

When the host's IN token strobe arrives, the controller picks one of three answers. A halted endpoint answers STALL. An unarmed endpoint answers NAK. An armed endpoint copies its committed bytes from the packet store into a transmit buffer, then streams them out with valid, last and zero-length flags plus the DATA0/DATA1 selector. After the packet the controller waits for the host's ACK or a timeout. ACK releases the store for the next packet and flips the data toggle. A timeout keeps everything armed, so the next IN token resends the same bytes under the same toggle. Token decoding, CRC generation and line coding sit outside this block.

Top module: `inep_commit_ctrl`

## Requirements
- R1: While the endpoint is not armed, an IN token produces a one-cycle NAK strobe and no data beat, even if bytes have been written.
- R2: A commit strobe on an unarmed endpoint sets `tx_armed` to 1 and loads `valid_size` with the number of bytes accepted since the last release. `valid_size` never exceeds MAX_PKT.
- R3: An IN token on an armed endpoint with `valid_size` = N > 0 yields exactly N consecutive beats with `tx_valid` = 1. The beats carry the written bytes in write order, and `tx_last` = 1 only on the Nth beat.
- R4: An IN token on an endpoint armed with zero bytes yields exactly one beat with `tx_valid`, `tx_last` and `tx_zlp` all 1.
- R5: While `ep_halt` = 1, an IN token produces a one-cycle STALL strobe and no data or NAK, whether or not the endpoint is armed.
- R6: An ACK strobe after a packet clears `tx_armed` and returns `valid_size` to 0. The next bytes written start a new packet at position 0.
- R7: A timeout strobe after a packet leaves `tx_armed`, `valid_size` and the toggle unchanged. The next IN token resends the identical bytes with the same `tx_pid1`.
- R8: `tx_pid1` (0 = DATA0, 1 = DATA1) is 0 after reset. It inverts only on an ACKed packet and returns to 0 on a `tgl_clr` strobe.
- R9: A write made when MAX_PKT bytes are already held is discarded and sets `wr_ovf`. `wr_ovf` stays 1 until reset.
- R10: Writes made while the endpoint is armed are discarded. `valid_size` and the transmitted bytes stay as committed.
- R11: Each accepted token yields exactly one kind of response. NAK, STALL and a data beat never appear in the same cycle, and tokens that arrive during a readout or while waiting for a handshake are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Processor byte write strobe |
| cpu_wdata | input | DATA_W | Byte being written |
| cpu_commit | input | 1 | Commit strobe (transmit-enable set) |
| ep_halt | input | 1 | Endpoint halted, answer STALL |
| tgl_clr | input | 1 | Force data toggle to DATA0 |
| tok_in | input | 1 | IN token received strobe |
| hs_ack | input | 1 | Host ACK received strobe |
| hs_tmo | input | 1 | Handshake timeout strobe |
| tx_valid | output | 1 | Data beat valid |
| tx_data | output | DATA_W | Data beat byte |
| tx_last | output | 1 | Final beat of packet |
| tx_zlp | output | 1 | Beat marks a zero-length packet |
| tx_pid1 | output | 1 | Data PID selector, 1 = DATA1 |
| hs_nak | output | 1 | Send NAK strobe |
| hs_stall | output | 1 | Send STALL strobe |
| tx_armed | output | 1 | Transmit-enable readback |
| valid_size | output | $clog2(MAX_PKT+1) | Committed byte count |
| wr_ovf | output | 1 | Sticky write overflow flag |

## Verification
The properties assume strobe-shaped inputs. They also assume the host sends ACK or timeout only while waiting for a handshake, and that a commit never coincides with a write. The bench drives every input for whole cycles from the falling edge and issues at most one strobe at a time. It sends handshakes only after the last beat of a packet. It sweeps every packet length from 0 to MAX_PKT and mixes in early tokens, writes while armed, timeouts, halts and toggle clears.

// File: rtl/inep_pkg.sv
package inep_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_SEND = 2'd2,
      ST_WAIT = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      RSP_NONE  = 2'd0,
      RSP_NAK   = 2'd1,
      RSP_STALL = 2'd2,
      RSP_DATA  = 2'd3
   } tok_rsp_e;
endpackage

// File: rtl/inep_fill.sv
module inep_fill #(
   parameter int MAX_PKT = 64,
   parameter int DATA_W  = 8,
   parameter int CNT_W   = $clog2(MAX_PKT + 1),
   parameter int IDX_W   = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              release_i,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              armed,
   output logic [CNT_W-1:0]  vsize,
   output logic              ovf
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_PKT);

   logic [DATA_W-1:0] mem [MAX_PKT];
   logic [CNT_W-1:0]  wcnt;
   logic              wr_open;
   logic              wr_ok;
   logic              wr_over;
   logic              arm_now;

   assign wr_open = wr_en && !armed && !commit;
   assign wr_ok   = wr_open && (wcnt < FULL_CNT);
   assign wr_over = wr_open && (wcnt == FULL_CNT);
   assign arm_now = commit && !armed;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wcnt[IDX_W-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt  <= '0;
         armed <= 1'b0;
         vsize <= '0;
         ovf   <= 1'b0;
      end else begin
         if (release_i) begin
            wcnt  <= '0;
            armed <= 1'b0;
            vsize <= '0;
         end else begin
            if (wr_ok) wcnt <= wcnt + CNT_W'(1);
            if (arm_now) begin
               armed <= 1'b1;
               vsize <= wcnt;
            end
         end
         if (wr_over) ovf <= 1'b1;
      end
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/inep_txbuf.sv
module inep_txbuf #(
   parameter int MAX_PKT = 64,
   parameter int DATA_W  = 8,
   parameter bit PREREAD = 1'b1,
   parameter int IDX_W   = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
   input  logic              clk,
   input  logic              cp_en,
   input  logic [IDX_W-1:0]  cp_idx,
   input  logic [DATA_W-1:0] cp_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] q
);
   generate
      if (PREREAD) begin : g_buffered
         logic [DATA_W-1:0] xbuf [MAX_PKT];
         always_ff @(posedge clk) begin
            if (cp_en) xbuf[cp_idx] <= cp_data;
         end
         assign q = xbuf[rd_idx];
      end else begin : g_direct
         logic unused_direct;
         assign unused_direct = ^{clk, cp_en, cp_idx, rd_idx};
         assign q = cp_data;
      end
   endgenerate
endmodule

// File: rtl/inep_seq.sv
module inep_seq
   import inep_pkg::*;
#(
   parameter int MAX_PKT = 64,
   parameter int DATA_W  = 8,
   parameter bit PREREAD = 1'b1,
   parameter int CNT_W   = $clog2(MAX_PKT + 1),
   parameter int IDX_W   = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_in,
   input  logic              ack_i,
   input  logic              tmo_i,
   input  logic              tgl_clr,
   input  logic              halt,
   input  logic              armed,
   input  logic [CNT_W-1:0]  vsize,
   input  logic [DATA_W-1:0] bufq,
   output logic [IDX_W-1:0]  idx,
   output logic              cp_en,
   output logic              release_o,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   output logic              tx_zlp,
   output logic              toggle,
   output logic              hs_nak,
   output logic              hs_stall
);
   seq_state_e st;
   tok_rsp_e   rsp;
   logic       is_zlp;
   logic       at_end;

   assign is_zlp = (vsize == '0);
   assign at_end = (CNT_W'(idx) == vsize - CNT_W'(1));

   always_comb begin
      rsp = RSP_NONE;
      if (st == ST_IDLE && tok_in) begin
         if (halt)       rsp = RSP_STALL;
         else if (!armed) rsp = RSP_NAK;
         else            rsp = RSP_DATA;
      end
   end

   assign cp_en     = (st == ST_PRE);
   assign release_o = (st == ST_WAIT) && ack_i;
   assign tx_valid  = (st == ST_SEND);
   assign tx_data   = tx_valid ? bufq : '0;
   assign tx_zlp    = tx_valid && is_zlp;
   assign tx_last   = tx_valid && (is_zlp || at_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         idx      <= '0;
         hs_nak   <= 1'b0;
         hs_stall <= 1'b0;
      end else begin
         hs_nak   <= (rsp == RSP_NAK);
         hs_stall <= (rsp == RSP_STALL);
         unique case (st)
            ST_IDLE: begin
               idx <= '0;
               if (rsp == RSP_DATA) begin
                  if (is_zlp || !PREREAD) st <= ST_SEND;
                  else                    st <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (at_end) begin
                  idx <= '0;
                  st  <= ST_SEND;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            ST_SEND: begin
               if (is_zlp || at_end) begin
                  idx <= '0;
                  st  <= ST_WAIT;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            ST_WAIT: begin
               if (ack_i || tmo_i) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         toggle <= 1'b0;
      else if (tgl_clr)   toggle <= 1'b0;
      else if (release_o) toggle <= ~toggle;
   end
endmodule

// File: rtl/inep_commit_ctrl.sv
module inep_commit_ctrl #(
   parameter int MAX_PKT = 64,
   parameter int DATA_W  = 8,
   parameter bit PREREAD = 1'b1,
   localparam int CNT_W  = $clog2(MAX_PKT + 1),
   localparam int IDX_W  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_commit,
   input  logic              ep_halt,
   input  logic              tgl_clr,
   input  logic              tok_in,
   input  logic              hs_ack,
   input  logic              hs_tmo,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   output logic              tx_zlp,
   output logic              tx_pid1,
   output logic              hs_nak,
   output logic              hs_stall,
   output logic              tx_armed,
   output logic [CNT_W-1:0]  valid_size,
   output logic              wr_ovf
);
   initial begin
      assert (MAX_PKT >= 1 && MAX_PKT <= 1024)
         else $error("MAX_PKT out of range");
      assert (DATA_W >= 1)
         else $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] store_q;
   logic [DATA_W-1:0] buf_q;
   logic              cp_en;
   logic              rel;

   inep_fill #(
      .MAX_PKT (MAX_PKT),
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W),
      .IDX_W   (IDX_W)
   ) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cpu_wr),
      .wr_data   (cpu_wdata),
      .commit    (cpu_commit),
      .release_i (rel),
      .rd_idx    (idx),
      .rd_data   (store_q),
      .armed     (tx_armed),
      .vsize     (valid_size),
      .ovf       (wr_ovf)
   );

   inep_txbuf #(
      .MAX_PKT (MAX_PKT),
      .DATA_W  (DATA_W),
      .PREREAD (PREREAD),
      .IDX_W   (IDX_W)
   ) u_txbuf (
      .clk     (clk),
      .cp_en   (cp_en),
      .cp_idx  (idx),
      .cp_data (store_q),
      .rd_idx  (idx),
      .q       (buf_q)
   );

   inep_seq #(
      .MAX_PKT (MAX_PKT),
      .DATA_W  (DATA_W),
      .PREREAD (PREREAD),
      .CNT_W   (CNT_W),
      .IDX_W   (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tok_in    (tok_in),
      .ack_i     (hs_ack),
      .tmo_i     (hs_tmo),
      .tgl_clr   (tgl_clr),
      .halt      (ep_halt),
      .armed     (tx_armed),
      .vsize     (valid_size),
      .bufq      (buf_q),
      .idx       (idx),
      .cp_en     (cp_en),
      .release_o (rel),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_last   (tx_last),
      .tx_zlp    (tx_zlp),
      .toggle    (tx_pid1),
      .hs_nak    (hs_nak),
      .hs_stall  (hs_stall)
   );
endmodule

// File: rtl/inep_commit_chk.sv
module inep_commit_chk #(
   parameter int MAX_PKT = 64,
   localparam int CNT_W  = $clog2(MAX_PKT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_commit,
   input logic             hs_ack,
   input logic             tgl_clr,
   input logic             tx_valid,
   input logic             tx_last,
   input logic             tx_zlp,
   input logic             tx_pid1,
   input logic             hs_nak,
   input logic             hs_stall,
   input logic             tx_armed,
   input logic [CNT_W-1:0] valid_size,
   input logic             wr_ovf
);
   AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_valid, hs_nak, hs_stall})); // R11
   AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      valid_size <= CNT_W'(MAX_PKT)); // R2
   AST_ARM_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_armed) |-> $past(cpu_commit)); // R2
   AST_SIZE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_armed && $past(tx_armed)) |-> $stable(valid_size)); // R10
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_ovf) |-> wr_ovf); // R9
   AST_TOGGLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_pid1) |-> ($past(hs_ack) || $past(tgl_clr))); // R8
   AST_DISARM_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_armed) |-> $past(hs_ack)); // R6
   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid); // R3
   AST_ZLP_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_zlp |-> (tx_last && valid_size == '0)); // R4
   AST_NAK_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      hs_nak |-> !tx_armed); // R1
endmodule

bind inep_commit_ctrl inep_commit_chk #(.MAX_PKT(MAX_PKT)) u_chk (.*);

// File: tb/inep_commit_ctrl_bench.sv
module inep_commit_ctrl_bench;
   localparam int MAXP = 64;
   localparam int CW   = $clog2(MAXP + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_wr = 0, cpu_commit = 0, ep_halt = 0, tgl_clr = 0;
   logic tok_in = 0, hs_ack = 0, hs_tmo = 0;
   logic [7:0] cpu_wdata = '0;
   logic tx_valid, tx_last, tx_zlp, tx_pid1, hs_nak, hs_stall, tx_armed, wr_ovf;
   logic [7:0] tx_data;
   logic [CW-1:0] valid_size;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [7:0] got [MAXP+1];
   int got_n, got_kind;
   bit got_zlp, got_pid, got_mix;
   bit exp_tgl = 1'b0;

   always #4 clk = ~clk;

   inep_commit_ctrl #(.MAX_PKT(MAXP), .DATA_W(8), .PREREAD(1'b1)) u_inep_commit_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_commit(cpu_commit), .ep_halt(ep_halt), .tgl_clr(tgl_clr),
      .tok_in(tok_in), .hs_ack(hs_ack), .hs_tmo(hs_tmo),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp),
      .tx_pid1(tx_pid1), .hs_nak(hs_nak), .hs_stall(hs_stall),
      .tx_armed(tx_armed), .valid_size(valid_size), .wr_ovf(wr_ovf));

   function automatic logic [7:0] pat(int seed, int i);
      return 8'((seed * 29 + i * 3 + 1) & 255);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic write_bytes(int n, int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cpu_wr = 1'b1;
         cpu_wdata = pat(seed, i);
      end
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic pulse_commit();
      @(negedge clk); cpu_commit = 1'b1;
      @(negedge clk); cpu_commit = 1'b0;
   endtask

   task automatic pulse_ack();
      @(negedge clk); hs_ack = 1'b1;
      @(negedge clk); hs_ack = 1'b0;
   endtask

   task automatic pulse_tmo();
      @(negedge clk); hs_tmo = 1'b1;
      @(negedge clk); hs_tmo = 1'b0;
   endtask

   // Issue one IN token and collect whatever response follows
   task automatic token();
      got_n = 0; got_kind = 0; got_zlp = 0; got_pid = 0; got_mix = 0;
      @(negedge clk); tok_in = 1'b1;
      @(negedge clk); tok_in = 1'b0;
      for (int c = 0; c < 400; c++) begin
         if (c > 0) @(negedge clk);
         if (tx_valid && (hs_nak || hs_stall)) got_mix = 1;
         if (hs_nak)   begin got_kind = 1; break; end
         if (hs_stall) begin got_kind = 2; break; end
         if (tx_valid) begin
            got_pid = tx_pid1;
            if (tx_zlp) got_zlp = 1;
            else if (got_n <= MAXP) begin got[got_n] = tx_data; got_n++; end
            if (tx_last) begin got_kind = 3; break; end
         end
      end
      chk(!got_mix, "R11 mixed response", 1, 0);
   endtask

   task automatic check_pkt(int n, int seed, string req);
      chk(got_kind == 3, {req, " kind"}, got_kind, 3);
      chk(got_n == n, {req, " length"}, got_n, n);
      chk(got_zlp == (n == 0), "R4 zlp flag", got_zlp, n == 0);
      chk(got_pid == exp_tgl, "R8 pid", got_pid, exp_tgl);
      for (int i = 0; i < n && i < got_n; i++)
         chk(got[i] == pat(seed, i), {req, " byte"}, got[i], pat(seed, i));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_armed == 0, "R2 reset armed", tx_armed, 0);
      chk(valid_size == 0, "R2 reset size", valid_size, 0);
      chk(wr_ovf == 0, "R9 reset ovf", wr_ovf, 0);
      chk(tx_valid == 0, "R3 reset valid", tx_valid, 0);
      chk(tx_pid1 == 0, "R8 reset pid", tx_pid1, 0);

      // Sweep every packet length
      for (int n = 0; n <= MAXP; n++) begin
         write_bytes(n, n);
         if (n % 9 == 1) begin
            token();
            chk(got_kind == 1, "R1 nak before commit", got_kind, 1);
         end
         pulse_commit();
         chk(tx_armed == 1, "R2 armed", tx_armed, 1);
         chk(valid_size == CW'(n), "R2 size", valid_size, n);
         if (n % 7 == 3) begin
            write_bytes(3, 200);
            chk(valid_size == CW'(n), "R10 size kept", valid_size, n);
         end
         token();
         check_pkt(n, n, (n == 0) ? "R4" : ((n % 7 == 3) ? "R10" : "R3"));
         if (n % 5 == 0) begin
            pulse_tmo();
            chk(tx_armed == 1, "R7 still armed", tx_armed, 1);
            chk(valid_size == CW'(n), "R7 size kept", valid_size, n);
            token();
            check_pkt(n, n, "R7");
         end
         pulse_ack();
         exp_tgl = ~exp_tgl;
         chk(tx_armed == 0, "R6 disarmed", tx_armed, 0);
         chk(valid_size == 0, "R6 size released", valid_size, 0);
         chk(tx_pid1 == exp_tgl, "R8 flip after ack", tx_pid1, exp_tgl);
         if (n == 20 || n == 41) begin
            @(negedge clk); tgl_clr = 1'b1;
            @(negedge clk); tgl_clr = 1'b0;
            exp_tgl = 1'b0;
            chk(tx_pid1 == 0, "R8 clear", tx_pid1, 0);
         end
      end
      chk(wr_ovf == 0, "R9 no false ovf", wr_ovf, 0);

      // Halt takes priority over NAK and data
      ep_halt = 1'b1;
      token();
      chk(got_kind == 2, "R5 stall unarmed", got_kind, 2);
      write_bytes(2, 5);
      pulse_commit();
      token();
      chk(got_kind == 2, "R5 stall armed", got_kind, 2);
      chk(tx_armed == 1, "R5 still armed", tx_armed, 1);
      ep_halt = 1'b0;
      token();
      check_pkt(2, 5, "R5");
      pulse_ack();
      exp_tgl = ~exp_tgl;

      // Unarmed endpoint naks repeatedly
      token();
      chk(got_kind == 1, "R1 nak empty", got_kind, 1);

      // Overflow: one byte past the limit
      write_bytes(MAXP + 1, 77);
      chk(wr_ovf == 1, "R9 ovf set", wr_ovf, 1);
      pulse_commit();
      chk(valid_size == CW'(MAXP), "R9 size capped", valid_size, MAXP);
      token();
      check_pkt(MAXP, 77, "R9");
      pulse_ack();
      exp_tgl = ~exp_tgl;
      chk(wr_ovf == 1, "R9 ovf sticky", wr_ovf, 1);

      finish_run();
   end
endmodule